// File: doc/BRIEF.md
# Programmable Slow Blink Clock Generator

This block drives two independent slow square waves, meant for LED blinking or slow strobes on general-purpose pins. A single 32-bit read-write configuration word holds, for each output, a timebase select, a high duration and a low duration. The durations are counted in ticks of the selected timebase.

One shared prescaler divides the system clock into four nested tick strobes. The slowest strobe is 512 times the period of the fastest. Each output owns a 7-bit down counter. The counter is loaded with the high duration at the start of a high phase and with the low duration at the start of a low phase. It counts down only on the selected strobe. When a tick finds the counter at zero, the output toggles and the counter reloads from the field that belongs to the new phase.

The fastest tick period is the parameter `BASE_CYCLES`, given in system clocks. Its default, 25000, gives 250 µs at 100 MHz.

Top module: `slow_blink_gen`

## Requirements
- R1: `rd_data` always shows the configuration word. The word is 32'hFFFF_FFFF after reset and takes `wr_data` on the clock edge where `wr_en` is high. It does not change at any other time.
- R2: After reset both outputs are high. With the reset configuration (timebase 3, high field 127), that first high phase lasts 128 × 512 × `BASE_CYCLES` clocks, so the outputs stay high far beyond 1500 clocks.
- R3: Output 0 stays high for (H+1) ticks and low for (L+1) ticks, and repeats. H is bits 13:7 of the configuration word and L is bits 6:0.
- R4: A duration field of 0 gives a phase exactly one tick long.
- R5: The timebase select of output 0 is bits 15:14. The values 0, 1, 2 and 3 give tick periods of 1, 8, 64 and 512 times `BASE_CYCLES` clocks.
- R6: Output 1 uses bits 31:30 as its timebase select, bits 29:23 as its high duration and bits 22:16 as its low duration. It runs independently of output 0.
- R7: A new duration written while an output is running is used only at that output's next phase reload. A write never shortens or lengthens the phase in progress. A new timebase select applies from the next tick of the new timebase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Configuration word to write |
| rd_data | output | 32 | Current configuration word |
| blink_o | output | 2 | Square-wave outputs, bit 0 is output 0 |

## Verification
Phase lengths are measured in clocks between output edges for every timebase select and for zero-valued fields. A design with an off-by-one reload would shorten each phase by one tick. A design with a wrong divider tap would scale every phase by the wrong factor. The bench rewrites a duration one cycle after a phase starts and expects that phase to keep its old length. A design that reloads on a write would cut the phase short. Output 1 is measured while output 0 is being reconfigured, which exposes swapped or overlapping field slices.

// File: rtl/blink_pkg.sv
package blink_pkg;
    localparam int DUR_W    = 7;
    localparam int NUM_TAPS = 4;
    localparam int SEL_W    = $clog2(NUM_TAPS);

    // Field order matches the per-output slice of the configuration word
    typedef struct packed {
        logic [SEL_W-1:0] base;
        logic [DUR_W-1:0] hi;
        logic [DUR_W-1:0] lo;
    } ch_cfg_t;

    localparam int CFG_W = $bits(ch_cfg_t);
endpackage

// File: rtl/blink_prescaler.sv
module blink_prescaler #(
    parameter int BASE_CYCLES = 25000,
    parameter int DIV_LOG     = 3,
    parameter int NUM_TAPS    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [NUM_TAPS-1:0] tick_o
);
    localparam int BW = (BASE_CYCLES > 1) ? $clog2(BASE_CYCLES) : 1;
    localparam int CW = DIV_LOG * (NUM_TAPS - 1);

    typedef struct packed {
        logic [BW-1:0] base_cnt;
        logic [CW-1:0] div_cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic       base_wrap;

    assign base_wrap = (st_q.base_cnt == BW'(BASE_CYCLES - 1));

    always_comb begin
        st_d = st_q;
        if (base_wrap) begin
            st_d.base_cnt = '0;
            st_d.div_cnt  = st_q.div_cnt + CW'(1);
        end else begin
            st_d.base_cnt = st_q.base_cnt + BW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o[0] = base_wrap;
    for (genvar k = 1; k < NUM_TAPS; k++) begin : g_tap
        assign tick_o[k] = base_wrap && (&st_q.div_cnt[k*DIV_LOG-1:0]);
    end
endmodule

// File: rtl/blink_channel.sv
module blink_channel
    import blink_pkg::*;
#(
    parameter logic [DUR_W-1:0] RESET_HI = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TAPS-1:0] tick_i,
    input  ch_cfg_t             cfg_i,
    output logic                level_o,
    output logic [DUR_W-1:0]    cnt_o
);
    typedef struct packed {
        logic             level;
        logic [DUR_W-1:0] cnt;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      step;

    assign step = tick_i[cfg_i.base];

    always_comb begin
        st_d = st_q;
        if (step) begin
            if (st_q.cnt == '0) begin
                st_d.level = ~st_q.level;
                st_d.cnt   = st_q.level ? cfg_i.lo : cfg_i.hi;
            end else begin
                st_d.cnt = st_q.cnt - DUR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.level <= 1'b1;
            st_q.cnt   <= RESET_HI;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;
    assign cnt_o   = st_q.cnt;
endmodule

// File: rtl/slow_blink_gen.sv
module slow_blink_gen
    import blink_pkg::*;
#(
    parameter int BASE_CYCLES = 25000,
    parameter int NUM_CH      = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [31:0]         wr_data,
    output logic [31:0]         rd_data,
    output logic [NUM_CH-1:0]   blink_o
);
    localparam int WORD_W = NUM_CH * CFG_W;

    logic [WORD_W-1:0]       cfg_d, cfg_q;
    logic [NUM_TAPS-1:0]     tick;
    logic [NUM_CH*DUR_W-1:0] cnt_all;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) cfg_d = wr_data[WORD_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '1;
        else        cfg_q <= cfg_d;
    end

    assign rd_data = cfg_q;

    blink_prescaler #(
        .BASE_CYCLES(BASE_CYCLES),
        .DIV_LOG    (3),
        .NUM_TAPS   (NUM_TAPS)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_o(tick)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ch_cfg_t cfg_slice;
        assign cfg_slice = ch_cfg_t'(cfg_q[i*CFG_W +: CFG_W]);

        blink_channel u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick),
            .cfg_i  (cfg_slice),
            .level_o(blink_o[i]),
            .cnt_o  (cnt_all[i*DUR_W +: DUR_W])
        );
    end
endmodule

// File: rtl/slow_blink_chk.sv
module slow_blink_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] rd_data,
    input logic [1:0]  blink_o,
    input logic [3:0]  tick,
    input logic [13:0] cnt_all
);
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(rd_data)); // R1

    AST_TICK_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        (tick[3] |-> tick[2]) and (tick[2] |-> tick[1]) and (tick[1] |-> tick[0])); // R5

    AST_TOGGLE_AT_ZERO0: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_o[0] != $past(blink_o[0])) |-> ($past(cnt_all[6:0]) == 7'd0)); // R3

    AST_TOGGLE_AT_ZERO1: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_o[1] != $past(blink_o[1])) |-> ($past(cnt_all[13:7]) == 7'd0)); // R6

    AST_TOGGLE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_o != $past(blink_o)) |-> $past(tick[0])); // R5

    AST_RELOAD_LO0: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blink_o[0]) |-> (cnt_all[6:0] == $past(rd_data[6:0]))); // R7

    AST_RELOAD_HI0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blink_o[0]) |-> (cnt_all[6:0] == $past(rd_data[13:7]))); // R7
endmodule

bind slow_blink_gen slow_blink_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .rd_data(rd_data),
    .blink_o(blink_o),
    .tick   (tick),
    .cnt_all(cnt_all)
);

// File: tb/tb_slow_blink_gen.sv
module tb_slow_blink_gen;
    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [1:0]  blink_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slow_blink_gen #(.BASE_CYCLES(BASE), .NUM_CH(2)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .rd_data(rd_data),
        .blink_o(blink_o)
    );

    function automatic logic [15:0] mk(input int b, input int hi, input int lo);
        return {b[1:0], hi[6:0], lo[6:0]};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_edge(input int ch, input logic lvl);
        logic p;
        p = blink_o[ch];
        forever begin
            @(negedge clk);
            if (blink_o[ch] != p && blink_o[ch] == lvl) break;
            p = blink_o[ch];
        end
    endtask

    task automatic count_phase(input int ch, input logic lvl, output int len);
        len = 0;
        do begin
            @(negedge clk);
            len++;
        end while (blink_o[ch] == lvl);
    endtask

    task automatic measure(input int ch, input logic lvl, output int len);
        wait_edge(ch, lvl);
        count_phase(ch, lvl, len);
    endtask

    task automatic t_reset;
        bit held;
        check("R1 reset word", int'(rd_data == 32'hFFFF_FFFF), 1);
        check("R2 reset outputs", int'(blink_o), 3);
        held = 1'b1;
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            if (blink_o != 2'b11) held = 1'b0;
        end
        check("R2 long first high phase", int'(held), 1);
    endtask

    task automatic t_base0;
        int len;
        write_cfg({mk(1, 0, 1), mk(0, 2, 5)});
        check("R1 readback", int'(rd_data == {mk(1, 0, 1), mk(0, 2, 5)}), 1);
        measure(0, 1'b0, len);
        check("R3 ch0 low len", len, 6 * BASE);
        measure(0, 1'b1, len);
        check("R3 ch0 high len", len, 3 * BASE);
        measure(1, 1'b0, len);
        check("R6 ch1 low len base1", len, 2 * 8 * BASE);
        measure(1, 1'b1, len);
        check("R4 ch1 zero high field", len, 1 * 8 * BASE);
    endtask

    task automatic t_base2;
        int len;
        write_cfg({mk(1, 0, 1), mk(2, 0, 0)});
        measure(0, 1'b0, len);
        check("R5 ch0 base2 low", len, 64 * BASE);
        measure(0, 1'b1, len);
        check("R4 R5 ch0 base2 high", len, 64 * BASE);
        measure(1, 1'b0, len);
        check("R6 ch1 unaffected", len, 2 * 8 * BASE);
    endtask

    task automatic t_midwrite;
        int len;
        write_cfg({mk(1, 0, 1), mk(0, 20, 20)});
        wait_edge(0, 1'b0);
        wait_edge(0, 1'b1);
        wr_en = 1'b1; wr_data = {mk(1, 0, 1), mk(0, 3, 20)};
        @(negedge clk);
        wr_en = 1'b0;
        len = 1;
        while (blink_o[0] == 1'b1) begin
            @(negedge clk);
            len++;
        end
        check("R7 phase not truncated", len, 21 * BASE);
        count_phase(0, 1'b0, len);
        check("R7 low after write", len, 21 * BASE);
        count_phase(0, 1'b1, len);
        check("R7 new high at reload", len, 4 * BASE);
    endtask

    task automatic t_base3;
        int len;
        write_cfg({mk(3, 0, 0), mk(0, 1, 1)});
        measure(1, 1'b0, len);
        check("R5 R6 ch1 base3 low", len, 512 * BASE);
        measure(1, 1'b1, len);
        check("R5 R6 ch1 base3 high", len, 512 * BASE);
        measure(0, 1'b1, len);
        check("R3 ch0 still running", len, 2 * BASE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_base0();
        t_base2();
        t_midwrite();
        t_base3();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule